// File: doc/BRIEF.md
# Flit-to-Phit Serializer

This block moves 70-bit flits across a 14-bit physical channel. Each flit holds a 64-bit payload in its low bits and a 6-bit control field in its high bits. The transmit half accepts a flit through a ready/valid handshake. It then sends the flit as five 14-bit phits on consecutive cycles, lowest slice first, and marks the first phit so that the far end can find where each flit begins.

The receive half shifts arriving phits into a flit-wide register and presents the rebuilt flit one cycle after its fifth phit. It also follows the packet framing carried in the control field. Packets are read or write requests of exactly one flit or exactly eight flits. The receive half raises a frame-error flag on any flit that breaks that framing.

The two halves share a clock and reset but are otherwise independent. A link is formed by wiring one block's phit outputs to another block's phit inputs.

Top module: `flit_phit_link`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `tx_flit_ready` is 1, `tx_phit_valid` is 0 and `rx_flit_valid` is 0.
- R2: A flit accepted at a clock edge (`tx_flit_valid` and `tx_flit_ready` both 1) appears as five phits on the next five cycles. Phit k carries flit bits [14k+13:14k], with k running from 0 to 4. `tx_phit_valid` is 0 whenever no flit is in transit.
- R3: `tx_phit_first` is 1 exactly on phit 0 of each flit.
- R4: `tx_flit_ready` is 0 while phits 0 to 3 are on the link and 1 during phit 4. This allows flits to be sent back-to-back with no idle cycle between them.
- R5: After a first-marked phit and four further valid phits, `rx_flit_valid` pulses for one cycle, on the cycle after the fifth phit. `rx_flit` then equals the transmitted flit.
- R6: A valid phit without the first marker that arrives when no flit is being assembled is discarded. A first-marked phit that arrives in the middle of a flit discards the partial flit and starts a new one.
- R7: The control field occupies flit bits 69:64. Bit 64 is start of packet, bit 65 is write (0 = read), bit 66 is length (0 = one flit, 1 = eight flits) and bit 67 is last flit. Bits 68 and 69 are zero. A well-formed packet of either length raises no frame error, and all of its flits are delivered.
- R8: `rx_frame_err` is 1, together with `rx_flit_valid`, for each of these flits: a flit without start of packet that arrives outside a packet; a start flit that arrives inside an open packet, which reopens a packet; a flit whose last bit disagrees with the declared length. After a flit marked last, or after the declared length is reached, the receiver is outside a packet.
- R9: Idle cycles are allowed between flits on the transmit side and between phits on the receive side. During such a gap no phit is sent and no partial flit is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_flit_valid | input | 1 | A flit is offered for transmission |
| tx_flit_ready | output | 1 | A flit offered this cycle is taken |
| tx_flit | input | 70 | Flit to send: control in [69:64], payload in [63:0] |
| tx_phit | output | 14 | Outgoing phit |
| tx_phit_valid | output | 1 | `tx_phit` carries data |
| tx_phit_first | output | 1 | `tx_phit` is phit 0 of a flit |
| rx_phit | input | 14 | Incoming phit |
| rx_phit_valid | input | 1 | `rx_phit` carries data |
| rx_phit_first | input | 1 | `rx_phit` is phit 0 of a flit |
| rx_flit_valid | output | 1 | One-cycle pulse: a rebuilt flit is present |
| rx_flit | output | 70 | Rebuilt flit |
| rx_frame_err | output | 1 | The presented flit breaks the packet framing |

## Verification
The bench builds the block with its default values: 14-bit phits, five phits per flit, 64 payload bits, 6 control bits and long packets of eight flits. These sizes bring two things within reach. The ready pulse during the fifth phit is exercised by back-to-back eight-flit packets. Every path through the framing check is reached by short, long, truncated, over-long and restarted packets. The receive side is also driven directly, with stray phits, gaps and a restart in the middle of a flit, so that alignment is tested apart from the transmitter.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
    // Bit offsets inside the control field of a flit.
    localparam int CTL_START = 0;
    localparam int CTL_WRITE = 1;
    localparam int CTL_LONG  = 2;
    localparam int CTL_LAST  = 3;
endpackage

// File: rtl/fpl_serializer.sv
module fpl_serializer #(
    parameter int PHIT_W = 14,
    parameter int PHITS  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [PHIT_W*PHITS-1:0]   in_flit,
    output logic [PHIT_W-1:0]         phit,
    output logic                      phit_valid,
    output logic                      phit_first
);
    localparam int FLIT_W = PHIT_W * PHITS;
    localparam int CW     = $clog2(PHITS);
    localparam logic [CW-1:0] LAST_SLOT = CW'(PHITS - 1);

    typedef struct packed {
        logic              busy;
        logic [CW-1:0]     cnt;
        logic [FLIT_W-1:0] sh;
    } ser_t;

    ser_t st_d, st_q;

    assign in_ready   = !st_q.busy || (st_q.cnt == LAST_SLOT);
    assign phit       = st_q.sh[PHIT_W-1:0];
    assign phit_valid = st_q.busy;
    assign phit_first = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (in_valid && in_ready) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.sh   = in_flit;
        end else if (st_q.busy) begin
            st_d.sh = st_q.sh >> PHIT_W;
            if (st_q.cnt == LAST_SLOT) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (phit_valid && phit_first));
    p_first_holds_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phit_first |-> !in_ready);
    p_stream_unbroken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phit_valid && !in_ready) |=> (phit_valid && !phit_first));
endmodule

// File: rtl/fpl_deserializer.sv
module fpl_deserializer #(
    parameter int PHIT_W = 14,
    parameter int PHITS  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PHIT_W-1:0]         phit,
    input  logic                      phit_valid,
    input  logic                      phit_first,
    output logic                      out_valid,
    output logic [PHIT_W*PHITS-1:0]   out_flit
);
    localparam int FLIT_W = PHIT_W * PHITS;
    localparam int CW     = $clog2(PHITS);
    localparam logic [CW-1:0] LAST_SLOT = CW'(PHITS - 1);

    typedef struct packed {
        logic [CW-1:0]     idx;
        logic [FLIT_W-1:0] sh;
        logic              ov;
        logic [FLIT_W-1:0] of;
    } des_t;

    des_t st_d, st_q;
    logic [FLIT_W-1:0] shifted;

    assign shifted   = {phit, st_q.sh[FLIT_W-1:PHIT_W]};
    assign out_valid = st_q.ov;
    assign out_flit  = st_q.of;

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        if (phit_valid) begin
            if (phit_first) begin
                st_d.sh  = shifted;
                st_d.idx = CW'(1);
            end else if (st_q.idx != '0) begin
                st_d.sh = shifted;
                if (st_q.idx == LAST_SLOT) begin
                    st_d.idx = '0;
                    st_d.ov  = 1'b1;
                    st_d.of  = shifted;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_flit_follows_phit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(phit_valid));
    p_stray_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phit_valid && !phit_first && st_q.idx == '0) |=> !out_valid);
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/fpl_frame_check.sv
module fpl_frame_check #(
    parameter int LONG_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flit_valid,
    input  logic is_start,
    input  logic is_long,
    input  logic is_last,
    output logic frame_err
);
    localparam int LW = $clog2(LONG_LEN);

    typedef struct packed {
        logic          in_pkt;
        logic [LW-1:0] owed;
    } frm_t;

    frm_t st_d, st_q;
    logic [LW-1:0] rem;
    logic          active;

    always_comb begin
        st_d      = st_q;
        frame_err = 1'b0;
        rem       = '0;
        active    = 1'b0;
        if (flit_valid) begin
            if (is_start) begin
                rem       = is_long ? LW'(LONG_LEN - 1) : '0;
                active    = 1'b1;
                frame_err = st_q.in_pkt || (is_last != (rem == '0));
            end else if (st_q.in_pkt) begin
                rem       = st_q.owed - 1'b1;
                active    = 1'b1;
                frame_err = (is_last != (rem == '0));
            end else begin
                frame_err = 1'b1;
            end
        end
        if (active) begin
            st_d.in_pkt = !is_last && (rem != '0);
            st_d.owed   = rem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_last_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && is_last) |=> !st_q.in_pkt);
    p_short_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && is_start && !is_long) |=> !st_q.in_pkt);
    p_open_pkt_owes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.in_pkt |-> (st_q.owed != '0));
endmodule

// File: rtl/flit_phit_link.sv
module flit_phit_link #(
    parameter int PHIT_W   = 14,
    parameter int PHITS    = 5,
    parameter int DATA_W   = 64,
    parameter int CTRL_W   = 6,
    parameter int LONG_LEN = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_flit_valid,
    output logic                     tx_flit_ready,
    input  logic [DATA_W+CTRL_W-1:0] tx_flit,
    output logic [PHIT_W-1:0]        tx_phit,
    output logic                     tx_phit_valid,
    output logic                     tx_phit_first,
    input  logic [PHIT_W-1:0]        rx_phit,
    input  logic                     rx_phit_valid,
    input  logic                     rx_phit_first,
    output logic                     rx_flit_valid,
    output logic [DATA_W+CTRL_W-1:0] rx_flit,
    output logic                     rx_frame_err
);
    import fpl_pkg::*;

    localparam int FLIT_W = DATA_W + CTRL_W;

    logic [CTRL_W-1:0] rx_ctl;
    assign rx_ctl = rx_flit[FLIT_W-1:DATA_W];

    fpl_serializer #(.PHIT_W(PHIT_W), .PHITS(PHITS)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (tx_flit_valid),
        .in_ready   (tx_flit_ready),
        .in_flit    (tx_flit),
        .phit       (tx_phit),
        .phit_valid (tx_phit_valid),
        .phit_first (tx_phit_first)
    );

    fpl_deserializer #(.PHIT_W(PHIT_W), .PHITS(PHITS)) u_des (
        .clk        (clk),
        .rst_n      (rst_n),
        .phit       (rx_phit),
        .phit_valid (rx_phit_valid),
        .phit_first (rx_phit_first),
        .out_valid  (rx_flit_valid),
        .out_flit   (rx_flit)
    );

    fpl_frame_check #(.LONG_LEN(LONG_LEN)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flit_valid (rx_flit_valid),
        .is_start   (rx_ctl[CTL_START]),
        .is_long    (rx_ctl[CTL_LONG]),
        .is_last    (rx_ctl[CTL_LAST]),
        .frame_err  (rx_frame_err)
    );

    p_err_with_flit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> rx_flit_valid);
endmodule

// File: tb/flit_phit_link_tb_top.sv
module flit_phit_link_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        tx_v = 1'b0;
    logic        tx_rdy;
    logic [69:0] tx_f = '0;
    logic [13:0] tx_p;
    logic        tx_pv, tx_pf;
    logic        lb = 1'b1;
    logic [13:0] man_p = '0;
    logic        man_v = 1'b0, man_first = 1'b0;
    logic [13:0] rx_p;
    logic        rx_pv, rx_pf;
    logic        rx_v, rx_err;
    logic [69:0] rx_f;

    assign rx_p  = lb ? tx_p  : man_p;
    assign rx_pv = lb ? tx_pv : man_v;
    assign rx_pf = lb ? tx_pf : man_first;

    flit_phit_link dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_flit_valid(tx_v), .tx_flit_ready(tx_rdy), .tx_flit(tx_f),
        .tx_phit(tx_p), .tx_phit_valid(tx_pv), .tx_phit_first(tx_pf),
        .rx_phit(rx_p), .rx_phit_valid(rx_pv), .rx_phit_first(rx_pf),
        .rx_flit_valid(rx_v), .rx_flit(rx_f), .rx_frame_err(rx_err)
    );

    int total = 0, bad = 0, rx_cnt = 0, err_cnt = 0;
    bit run = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [69:0] act, input logic [69:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [69:0] mk(input logic [63:0] d, input bit st, input bit wr,
                                       input bit lng, input bit lst);
        return {2'b00, lst, lng, wr, st, d};
    endfunction

    // Reference model: transmit queue of {first, phit}; receive slot list; framing state.
    logic [14:0] txq[$];
    logic [13:0] pieces[5];
    int  ridx = 0;
    bit  exp_v = 0, exp_e = 0;
    logic [69:0] exp_f = '0;
    bit  in_pkt = 0;
    int  owed = 0;

    task automatic frame_eval(input logic [69:0] f, output bit e);
        bit st, lng, lst;
        int rem;
        st = f[64]; lng = f[66]; lst = f[67];
        e = 0;
        if (st) begin
            rem = lng ? 7 : 0;
            e = in_pkt || (lst != (rem == 0));
            in_pkt = !lst && rem != 0; owed = rem;
        end else if (in_pkt) begin
            rem = owed - 1;
            e = (lst != (rem == 0));
            in_pkt = !lst && rem != 0; owed = rem;
        end else e = 1;
    endtask

    always @(negedge clk) if (rst_n && run) begin
        int qs;
        qs = txq.size();
        chk(tx_rdy == (qs <= 1), "R4 tx_flit_ready", 70'(tx_rdy), 70'(qs <= 1));
        chk(tx_pv == (qs > 0), "R2 tx_phit_valid", 70'(tx_pv), 70'(qs > 0));
        if (qs > 0) begin
            chk(tx_p == txq[0][13:0], "R2 tx_phit data", 70'(tx_p), 70'(txq[0][13:0]));
            chk(tx_pf == txq[0][14], "R3 tx_phit_first", 70'(tx_pf), 70'(txq[0][14]));
            void'(txq.pop_front());
        end
        chk(rx_v == exp_v, "R5 rx_flit_valid", 70'(rx_v), 70'(exp_v));
        if (exp_v) begin
            chk(rx_f == exp_f, "R5 rx_flit", rx_f, exp_f);
            chk(rx_err == exp_e, "R8 rx_frame_err", 70'(rx_err), 70'(exp_e));
        end
        if (rx_v) rx_cnt++;
        if (rx_v && rx_err) err_cnt++;
        #1;
        if (tx_v && qs <= 1)
            for (int k = 0; k < 5; k++) txq.push_back({k == 0, tx_f[14*k +: 14]});
        exp_v = 0;
        if (rx_pv) begin
            if (rx_pf) begin pieces[0] = rx_p; ridx = 1; end
            else if (ridx > 0) begin
                pieces[ridx] = rx_p; ridx++;
                if (ridx == 5) begin
                    ridx = 0; exp_v = 1;
                    exp_f = {pieces[4], pieces[3], pieces[2], pieces[1], pieces[0]};
                    frame_eval(exp_f, exp_e);
                end
            end
        end
    end

    task automatic send(input logic [69:0] f);
        tx_v = 1'b1; tx_f = f;
        while (!tx_rdy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        tx_v = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic man(input bit v, input bit fst, input logic [13:0] p);
        man_v = v; man_first = fst; man_p = p;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r0, e0;
        logic [69:0] mf;
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(tx_rdy == 1'b1, "R1 ready in reset", 70'(tx_rdy), 70'd1);
        chk(tx_pv == 1'b0, "R1 phit valid in reset", 70'(tx_pv), 70'd0);
        chk(rx_v == 1'b0, "R1 flit valid in reset", 70'(rx_v), 70'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_rdy && !tx_pv && !rx_v, "R1 after release", {67'd0, tx_rdy, tx_pv, rx_v}, 70'b100);
        run = 1'b1;

        // R7: one-flit read request
        r0 = rx_cnt; e0 = err_cnt;
        send(mk(64'h0123_4567_89AB_CDEF, 1, 0, 0, 1));
        idle(8);
        chk(rx_cnt == r0 + 1 && err_cnt == e0, "R7 short packet", 70'(rx_cnt - r0), 70'd1);

        // R4/R7: eight-flit write back-to-back
        r0 = rx_cnt; e0 = err_cnt;
        for (int i = 0; i < 8; i++)
            send(mk({32'hA5A5_0000 + i, 32'hFFFF_0000 - i}, i == 0, 1, 1, i == 7));
        idle(8);
        chk(rx_cnt == r0 + 8 && err_cnt == e0, "R7 long packet", 70'(rx_cnt - r0), 70'd8);

        // R9: long read packet with idle gaps between flits
        r0 = rx_cnt;
        for (int i = 0; i < 8; i++) begin
            send(mk(64'hDEAD_BEEF_0000_0000 | 64'(i * 3), i == 0, 0, 1, i == 7));
            idle(i % 3);
        end
        idle(8);
        chk(rx_cnt == r0 + 8, "R9 gapped packet", 70'(rx_cnt - r0), 70'd8);

        // R8: framing violations
        e0 = err_cnt;
        send(mk(64'h1, 0, 0, 0, 0));          // body flit outside a packet
        send(mk(64'h2, 1, 1, 1, 0));          // long start
        send(mk(64'h3, 0, 1, 1, 0));
        send(mk(64'h4, 1, 0, 0, 1));          // start inside open packet
        send(mk(64'h5, 1, 0, 0, 0));          // short without last
        send(mk(64'h6, 1, 0, 1, 0));          // long start
        send(mk(64'h7, 0, 0, 1, 0));
        send(mk(64'h8, 0, 0, 1, 1));          // last too early
        idle(8);
        chk(err_cnt == e0 + 4, "R8 error count", 70'(err_cnt - e0), 70'd4);

        // R6/R9: drive the receiver directly
        lb = 1'b0;
        r0 = rx_cnt;
        mf = mk(64'hCAFE_F00D_1234_5678, 1, 1, 0, 1);
        man(1, 0, 14'h1111); man(1, 0, 14'h2222); man(1, 0, 14'h3333);   // stray phits
        man(1, 1, 14'h0AAA); man(1, 0, 14'h0BBB);                          // partial flit
        for (int k = 0; k < 5; k++) begin                                  // restart mid-flit
            man(1, k == 0, mf[14*k +: 14]);
            if (k == 2) begin man(0, 0, 14'h3FFF); man(0, 1, 14'h3FFF); end
        end
        man(0, 0, 14'h0); man(0, 0, 14'h0);
        chk(rx_cnt == r0 + 1, "R6 one flit after strays/restart", 70'(rx_cnt - r0), 70'd1);
        lb = 1'b1;
        idle(4);
        run = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule